// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block sits between a 32-bit register bus and an external successive-approximation converter. It runs one-pass conversion sweeps over up to sixteen analog inputs. Software sets the acquisition length and picks the inputs. It can also enable a data-ready interrupt for each input. Setting the run bit then starts a sweep.

During a sweep the block walks the selected inputs from the lowest index to the highest. For each input it holds a sampling window of programmable length, then runs a fixed conversion phase of `CONV_CYC` (14) clocks. At the start of that phase it sends a one-cycle request to the converter and takes the converter's 12-bit answer. Each answer goes into a result register for that input and sets a status bit that software clears by writing a one. The interrupt line is high while any pending status bit is also enabled.

When calibration is requested, the block runs one extra dummy conversion before the first input and throws its result away. When the sweep is finished, the run bit clears itself.

The sequencer has six states:
- IDLE waits for the run bit and goes to PICK when the mode is single-shot.
- PICK takes the dummy slot or the lowest pending input and goes to ACQ. When nothing is pending it goes back to IDLE and clears the run bit.
- ACQ counts the sampling window and goes to CONV.
- CONV counts the conversion phase. It goes to STORE if an answer has arrived, or to WAIT if not.
- WAIT holds until the answer arrives and then goes to STORE.
- STORE writes the result and returns to PICK.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and the busy bit (bit 0 at offset 0x00) is 0.
- R2: The register map is:
  - 0x00: status, with busy in bit 0.
  - 0x04: control, with sample length in bits 15:0, run in bit 16, mode in bits 19:18 and calibrate in bit 23.
  - 0x08: input select, bit n for input n.
  - 0x28: interrupt enable, bit n for input n.
  - 0x38: pending status, bit n for input n.
  - 0x80+4n: result of input n, in bits 11:0.

  Written fields read back as written. Unmapped offsets read 0.
- R3: Writing run=1 with mode 0 starts a sweep. With any other mode value no sweep starts and the control value stays as written.
- R4: Each selected input is converted exactly once, in ascending index order. With L the sample length, N the number of conversions and a converter latency of at most 13 clocks, the busy bit stays high for N·(L+17)+1 cycles.
- R5: Every conversion begins with `conv_sample` high for L+1 clocks. It is followed by a conversion phase of 14 clocks, and `conv_req` pulses in the first clock of that phase.
- R6: The answer on `res_data` with `res_valid` is stored in bits 11:0 of the input's result register. If no answer has arrived by the end of the conversion phase, the block waits for it.
- R7: A pending bit is set in the cycle its result register is written. Writing ones to 0x38 clears those bits only, and a set in the same cycle wins over a clear.
- R8: `irq` is the OR over n of (pending bit n AND enable bit n).
- R9: The run bit (bit 16 at 0x04) clears itself when the sweep ends.
- R10: With calibrate=1, one dummy conversion (`conv_dummy` high) runs before the first input. Its answer changes no result register and no pending bit.
- R11: Input-select writes during a sweep take effect only on the next sweep. Control writes while busy are ignored.
- R12: A sweep with no input selected and no calibration keeps busy high for exactly one cycle and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| conv_sample | output | 1 | High during the sampling window |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Input index being sampled or converted |
| conv_dummy | output | 1 | Current conversion is the calibration dummy |
| res_valid | input | 1 | Converter answer valid |
| res_data | input | 12 | Converter answer |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the next rising edge. The busy bit rises one clock after the run-bit write, and each conversion adds L+17 clocks plus any converter latency beyond 13. The bench counts busy cycles at falling edges and compares the count with that formula. It reads results, pending bits, the run bit and `irq` only after busy has dropped. The converter model is driven on falling edges. It logs the channel, the dummy flag and the counted sampling-window length at each request, so that order and window length are checked for every single conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_ACQ,
        S_CONV,
        S_WAIT,
        S_STORE
    } seq_state_e;

    localparam logic [7:0] OFS_STAT  = 8'h00;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_CHSEL = 8'h08;
    localparam logic [7:0] OFS_IEN   = 8'h28;
    localparam logic [7:0] OFS_IST   = 8'h38;
    localparam logic [7:0] OFS_RES   = 8'h80;

    localparam int BIT_RUN     = 16;
    localparam int BIT_MODE_LO = 18;
    localparam int BIT_CAL     = 23;

    localparam logic [1:0] MODE_SINGLE = 2'b00;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int RES_W  = 12,
    parameter int ACQ_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              clr_run,
    input  logic              store_we,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] store_ch,
    input  logic [RES_W-1:0]  store_data,
    output logic              run_en,
    output logic [1:0]        run_mode,
    output logic              cal_en,
    output logic [ACQ_W-1:0]  acq_len,
    output logic [NCH-1:0]    chsel,
    output logic [NCH-1:0]    ien,
    output logic [NCH-1:0]    ists
);

    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int RES_END = 32'(OFS_RES) + 4 * NCH;

    logic              wr_ctrl, wr_chsel, wr_ien, wr_ist;
    logic [NCH-1:0]    we_vec;
    logic [NCH-1:0]    clr_vec;
    logic [RES_W-1:0]  res_q [NCH];
    logic [ADDR_W-1:0] rd_off;
    logic [CH_W-1:0]   rd_idx;
    logic              rd_in_res;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign wr_chsel = wr_en && (wr_addr == ADDR_W'(OFS_CHSEL));
    assign wr_ien   = wr_en && (wr_addr == ADDR_W'(OFS_IEN));
    assign wr_ist   = wr_en && (wr_addr == ADDR_W'(OFS_IST));
    assign clr_vec  = wr_ist ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_len  <= '0;
            run_en   <= 1'b0;
            run_mode <= 2'b00;
            cal_en   <= 1'b0;
        end else if (wr_ctrl && !busy) begin
            acq_len  <= wr_data[ACQ_W-1:0];
            run_en   <= wr_data[BIT_RUN];
            run_mode <= wr_data[BIT_MODE_LO+1:BIT_MODE_LO];
            cal_en   <= wr_data[BIT_CAL];
        end else if (clr_run) begin
            run_en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chsel <= '0;
            ien   <= '0;
            ists  <= '0;
        end else begin
            if (wr_chsel) chsel <= wr_data[NCH-1:0];
            if (wr_ien)   ien   <= wr_data[NCH-1:0];
            ists <= (ists & ~clr_vec) | we_vec;
        end
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_res
            assign we_vec[n] = store_we && (store_ch == CH_W'(n));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         res_q[n] <= '0;
                else if (we_vec[n]) res_q[n] <= store_data;
            end
        end
    endgenerate

    assign rd_off    = rd_addr - ADDR_W'(OFS_RES);
    assign rd_idx    = rd_off[CH_W+1:2];
    assign rd_in_res = (32'(rd_addr) >= 32'(OFS_RES)) && (32'(rd_addr) < RES_END)
                       && (rd_addr[1:0] == 2'b00);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_STAT)) begin
            rd_data[0] = busy;
        end else if (rd_addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[ACQ_W-1:0]                 = acq_len;
            rd_data[BIT_RUN]                   = run_en;
            rd_data[BIT_MODE_LO+1:BIT_MODE_LO] = run_mode;
            rd_data[BIT_CAL]                   = cal_en;
        end else if (rd_addr == ADDR_W'(OFS_CHSEL)) begin
            rd_data[NCH-1:0] = chsel;
        end else if (rd_addr == ADDR_W'(OFS_IEN)) begin
            rd_data[NCH-1:0] = ien;
        end else if (rd_addr == ADDR_W'(OFS_IST)) begin
            rd_data[NCH-1:0] = ists;
        end else if (rd_in_res) begin
            rd_data[RES_W-1:0] = res_q[rd_idx];
        end
    end

    // R7
    sts_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ists & ~$past(ists)) != '0) |-> $past(store_we));

    // R7
    sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_ist) && !$past(store_we)) |-> ((ists & $past(wr_data[NCH-1:0])) == '0));

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int RES_W    = 12,
    parameter int ACQ_W    = 16,
    parameter int CONV_CYC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [1:0]       run_mode,
    input  logic             cal_en,
    input  logic [ACQ_W-1:0] acq_len,
    input  logic [NCH-1:0]   chsel,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic             busy,
    output logic             clr_run,
    output logic             conv_sample,
    output logic             conv_req,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_chan,
    output logic             conv_dummy,
    output logic             store_we,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] store_ch,
    output logic [RES_W-1:0] store_data
);

    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CC_W  = $clog2(CONV_CYC) + 1;
    localparam int CNT_W = (ACQ_W > CC_W) ? ACQ_W : CC_W;

    seq_state_e        state_q, state_d;
    logic [NCH-1:0]    mask_q;
    logic [CH_W-1:0]   ch_q;
    logic [CH_W-1:0]   low_idx;
    logic              cal_pend_q, dummy_q, got_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RES_W-1:0]  res_q;
    logic              cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        low_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_q[i]) low_idx = CH_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (run_en && run_mode == MODE_SINGLE) state_d = S_PICK;
            S_PICK:  if (cal_pend_q || mask_q != '0) state_d = S_ACQ;
                     else state_d = S_IDLE;
            S_ACQ:   if (cnt_zero) state_d = S_CONV;
            S_CONV:  if (cnt_zero) state_d = (got_q || res_valid) ? S_STORE : S_WAIT;
            S_WAIT:  if (res_valid) state_d = S_STORE;
            S_STORE: state_d = S_PICK;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            ch_q       <= '0;
            cal_pend_q <= 1'b0;
            dummy_q    <= 1'b0;
            got_q      <= 1'b0;
            cnt_q      <= '0;
            res_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    mask_q     <= chsel;
                    cal_pend_q <= cal_en;
                end
                S_PICK: begin
                    cnt_q <= CNT_W'(acq_len);
                    if (cal_pend_q) begin
                        dummy_q    <= 1'b1;
                        cal_pend_q <= 1'b0;
                    end else begin
                        dummy_q <= 1'b0;
                        ch_q    <= low_idx;
                    end
                end
                S_ACQ: begin
                    got_q <= 1'b0;
                    if (cnt_zero) cnt_q <= CNT_W'(CONV_CYC - 1);
                    else          cnt_q <= cnt_q - 1'b1;
                end
                S_CONV: begin
                    if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
                    if (res_valid) begin
                        res_q <= res_data;
                        got_q <= 1'b1;
                    end
                end
                S_WAIT: begin
                    if (res_valid) begin
                        res_q <= res_data;
                        got_q <= 1'b1;
                    end
                end
                S_STORE: begin
                    if (!dummy_q) mask_q[ch_q] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy        = (state_q != S_IDLE);
        clr_run     = (state_q == S_PICK) && !cal_pend_q && (mask_q == '0);
        conv_sample = (state_q == S_ACQ);
        conv_req    = (state_q == S_CONV) && (cnt_q == CNT_W'(CONV_CYC - 1));
        conv_chan   = ch_q;
        conv_dummy  = dummy_q;
        store_we    = (state_q == S_STORE) && !dummy_q;
        store_ch    = ch_q;
        store_data  = res_q;
    end

    // R5
    req_after_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(conv_sample));

    // R4
    sel_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_sample && !conv_dummy) |-> mask_q[ch_q]);

    // R5
    sample_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_sample) |-> conv_req);

endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] ists,
    input  logic [NCH-1:0] ien,
    output logic           irq
);

    assign irq = |(ists & ien);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int RES_W    = 12,
    parameter int ACQ_W    = 16,
    parameter int CONV_CYC = 14,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              conv_sample,
    output logic              conv_req,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_chan,
    output logic              conv_dummy,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    output logic              irq
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic             busy, clr_run, store_we, run_en, cal_en;
    logic [1:0]       run_mode;
    logic [CH_W-1:0]  store_ch;
    logic [RES_W-1:0] store_data;
    logic [ACQ_W-1:0] acq_len;
    logic [NCH-1:0]   chsel, ien, ists;

    adc_seq_regs #(
        .NCH(NCH), .RES_W(RES_W), .ACQ_W(ACQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .clr_run(clr_run),
        .store_we(store_we), .store_ch(store_ch), .store_data(store_data),
        .run_en(run_en), .run_mode(run_mode), .cal_en(cal_en), .acq_len(acq_len),
        .chsel(chsel), .ien(ien), .ists(ists)
    );

    adc_seq_fsm #(
        .NCH(NCH), .RES_W(RES_W), .ACQ_W(ACQ_W), .CONV_CYC(CONV_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .run_mode(run_mode), .cal_en(cal_en),
        .acq_len(acq_len), .chsel(chsel),
        .res_valid(res_valid), .res_data(res_data),
        .busy(busy), .clr_run(clr_run),
        .conv_sample(conv_sample), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_dummy(conv_dummy),
        .store_we(store_we), .store_ch(store_ch), .store_data(store_data)
    );

    adc_seq_irq #(.NCH(NCH)) u_irq (
        .ists(ists), .ien(ien), .irq(irq)
    );

    // R9
    run_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !run_en);

    // R10
    dummy_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_dummy && busy) |-> !store_we);

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        conv_sample, conv_req, conv_dummy, irq;
    logic [3:0]  conv_chan;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;

    always #4 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_sample(conv_sample), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_dummy(conv_dummy),
        .res_valid(res_valid), .res_data(res_data),
        .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // converter model and request log
    int          lat = 3;
    int          lat_cnt = 0;
    int          run_id = 0;
    int          samp_cnt = 0;
    int          nlog = 0;
    int          log_ch [64];
    bit          log_dm [64];
    int          log_acq [64];
    logic [11:0] pend = '0;
    logic [11:0] shadow [16];

    function automatic logic [11:0] conv_val(input int ch, input int rid);
        return 12'((ch * 37 + rid * 101 + 9) & 12'hFFF);
    endfunction

    always @(negedge clk) begin
        if (conv_sample) samp_cnt++;
        res_valid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                res_valid = 1'b1;
                res_data  = pend;
            end
        end
        if (conv_req) begin
            if (nlog < 64) begin
                log_ch[nlog]  = int'(conv_chan);
                log_dm[nlog]  = conv_dummy;
                log_acq[nlog] = samp_cnt;
            end
            nlog++;
            samp_cnt = 0;
            pend     = conv_dummy ? 12'hEEE : conv_val(int'(conv_chan), run_id);
            lat_cnt  = lat;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic measure_busy(output int dur);
        int t = 0;
        dur = 0;
        rd_addr = 8'h00;
        #1;
        while (!rd_data[0] && t < 10) begin @(negedge clk); #1; t++; end
        while (rd_data[0] && t < 150000) begin dur++; @(negedge clk); #1; t++; end
    endtask

    task automatic run_vec(input bit cal, input int acq, input logic [15:0] sel,
                           input logic [15:0] ie);
        int          dur, n, k, exp_dur, extra;
        logic [31:0] v;
        wr(8'h28, {16'h0, ie});
        wr(8'h08, {16'h0, sel});
        wr(8'h38, 32'h0000FFFF);
        nlog = 0; samp_cnt = 0; run_id++;
        wr(8'h04, (32'(cal) << 23) | 32'h0001_0000 | 32'(acq));
        measure_busy(dur);
        n = $countones(sel) + int'(cal);
        extra = (lat > 13) ? lat - 13 : 0;
        exp_dur = n * (acq + 17 + extra) + 1;
        // R4 duration
        chk("R4 busy cycles", dur, exp_dur);
        // R4 / R12 request count
        chk("R4 conversion count", nlog, n);
        k = 0;
        if (cal) begin
            // R10 dummy first
            chk("R10 dummy first", 32'(log_dm[0]), 32'd1);
            chk("R5 dummy window", log_acq[0], acq + 1);
            k = 1;
        end
        for (int c = 0; c < 16; c++) begin
            if (sel[c] && k < nlog) begin
                chk("R4 ascending order", log_ch[k], c);
                chk("R5 sample window", log_acq[k], acq + 1);
                k++;
                shadow[c] = conv_val(c, run_id);
            end
        end
        for (int c = 0; c < 16; c++) begin
            rd(8'h80 + 8'(4 * c), v);
            chk("R6 R10 result register", v, {20'h0, shadow[c]});
        end
        rd(8'h38, v);
        chk("R7 pending bits", v, {16'h0, sel});
        #1;
        chk("R8 irq level", irq, |(sel & ie));
        rd(8'h04, v);
        // R9
        chk("R9 run bit cleared", v[16], 1'b0);
    endtask

    // {cal, acq[15:0], chsel[15:0], ien[15:0]}
    localparam logic [48:0] VEC [7] = '{
        {1'b0, 16'd0,  16'h0001, 16'h0001},
        {1'b0, 16'd3,  16'h8421, 16'h0000},
        {1'b1, 16'd5,  16'h0006, 16'h0004},
        {1'b0, 16'd1,  16'hFFFF, 16'hFFFF},
        {1'b1, 16'd0,  16'h0000, 16'h0000},
        {1'b0, 16'd40, 16'h8000, 16'h8000},
        {1'b0, 16'd2,  16'h0000, 16'hFFFF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          dur;
        for (int c = 0; c < 16; c++) shadow[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 status", v, 0);
        rd(8'h04, v); chk("R1 control", v, 0);
        rd(8'h08, v); chk("R1 select", v, 0);
        rd(8'h28, v); chk("R1 enable", v, 0);
        rd(8'h38, v); chk("R1 pending", v, 0);
        rd(8'h80, v); chk("R1 result 0", v, 0);
        rd(8'hBC, v); chk("R1 result 15", v, 0);
        chk("R1 irq", irq, 0);

        // R2 readback and unmapped
        wr(8'h04, 32'h0088_1234);
        rd(8'h04, v); chk("R2 control fields", v, 32'h0088_1234);
        wr(8'h08, 32'h0000_A5C3);
        rd(8'h08, v); chk("R2 select", v, 32'h0000_A5C3);
        wr(8'h28, 32'h0000_3C00);
        rd(8'h28, v); chk("R2 enable", v, 32'h0000_3C00);
        rd(8'h3C, v); chk("R2 unmapped", v, 0);
        rd(8'hC0, v); chk("R2 past results", v, 0);

        // R3 non-single mode does not start
        nlog = 0;
        wr(8'h04, 32'h0005_0007);
        repeat (30) @(negedge clk);
        rd(8'h00, v); chk("R3 no start busy", v, 0);
        chk("R3 no request", nlog, 0);
        rd(8'h04, v); chk("R3 control kept", v, 32'h0005_0007);
        wr(8'h04, 32'h0);

        // table-driven sweeps
        for (int i = 0; i < 7; i++) begin
            run_vec(VEC[i][48], int'(VEC[i][47:32]), VEC[i][31:16], VEC[i][15:0]);
        end

        // R11 select and control writes during a sweep
        wr(8'h38, 32'h0000FFFF);
        wr(8'h08, 32'h0000_0002);
        nlog = 0; run_id++;
        wr(8'h04, 32'h0001_00C8);
        repeat (20) @(negedge clk);
        wr(8'h08, 32'h0000_0001);
        wr(8'h04, 32'h0000_0005);
        measure_busy(dur);
        chk("R11 one conversion", nlog, 1);
        chk("R11 old selection used", log_ch[0], 1);
        shadow[1] = conv_val(1, run_id);
        rd(8'h84, v); chk("R11 result ch1", v, {20'h0, shadow[1]});
        rd(8'h08, v); chk("R11 new select stored", v, 1);
        rd(8'h04, v); chk("R11 control write ignored", v, 32'h0000_00C8);

        // R7 partial write-one-to-clear, R8 enable masking
        run_vec(1'b0, 1, 16'h0006, 16'h0002);
        wr(8'h38, 32'h0000_0002);
        rd(8'h38, v); chk("R7 partial clear", v, 32'h0000_0004);
        #1; chk("R8 masked irq low", irq, 0);
        wr(8'h28, 32'h0000_0004);
        #1; chk("R8 irq high", irq, 1);
        wr(8'h38, 32'h0000_0004);
        #1; chk("R8 irq after clear", irq, 0);

        // R6 slow converter answer
        lat = 20;
        run_vec(1'b0, 2, 16'h0010, 16'h0010);
        lat = 3;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule